// File: doc/BRIEF.md
# Wide-to-Narrow Byte-Swapping Access Splitter

This block sits between a master that issues 64-bit accesses in big-endian byte order and a register port that speaks 32-bit little-endian words at consecutive word offsets. For each wide access it reverses the byte order of the write data and of the byte-lane mask. It then turns the access into zero, one or two narrow accesses, one for each 32-bit half that has at least one enabled lane.

On reads, the narrow results are placed back into their halves. Any half that was not accessed stays zero. The 64-bit word is then byte-reversed again and returned to the master. Both sides use valid/ready handshakes. Only one wide transaction is in flight at a time, and its response is raised after the last narrow response has arrived.

Top module: `be64_splitter`

## Requirements
- R1: The write data is byte-reversed before splitting: byte i of `wide_wdata` (bits 8i+7:8i) appears at byte 7-i of the reversed word. The reversed bits 31:0 are sent on the low narrow access and bits 63:32 on the high one.
- R2: For wide word offset n, the low half goes to narrow offset 2n (`nar_ofs` = {n,0}) and the high half to 2n+1 (`nar_ofs` = {n,1}).
- R3: A narrow access is issued for a half only when its reversed mask slice is non-zero. `nar_valid` never shows an all-zero `nar_mask`.
- R4: The mask is reversed the same way as the data bytes (bit i moves to bit 7-i). `nar_mask` carries reversed bits 3:0 for the low access and 7:4 for the high one.
- R5: When both halves are active, the low access is issued first and the high access second.
- R6: Read results from offset 2n fill bits 31:0 and those from 2n+1 fill bits 63:32. Halves not accessed read as zero. `wide_rdata` is the byte reversal of that assembled word.
- R7: A wide access with an all-zero mask produces no narrow access and completes with `wide_rdata` equal to zero.
- R8: Only one wide transaction is accepted at a time. `wide_ready` stays low from acceptance until the wide response is taken.
- R9: While `nar_valid` is high and `nar_ready` is low, the narrow request and all its fields stay unchanged.
- R10: `wide_rsp_valid` rises only after the last narrow response. It and `wide_rdata` hold until `wide_rsp_ready` is high.
- R11: After reset, `wide_ready` is high and `nar_valid` and `wide_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_valid | input | 1 | Wide request valid |
| wide_ready | output | 1 | Wide request accepted when high with valid |
| wide_write | input | 1 | 1 = write, 0 = read |
| wide_ofs | input | WOFS_W | Wide word offset n |
| wide_wdata | input | 64 | Big-endian write data |
| wide_mask | input | 8 | Byte-lane enables, one bit per byte |
| wide_rsp_valid | output | 1 | Wide response valid |
| wide_rsp_ready | input | 1 | Wide response taken |
| wide_rdata | output | 64 | Big-endian read result |
| nar_valid | output | 1 | Narrow request valid |
| nar_ready | input | 1 | Narrow request accepted |
| nar_write | output | 1 | Narrow request direction |
| nar_ofs | output | WOFS_W+1 | Narrow word offset |
| nar_wdata | output | 32 | Narrow write data |
| nar_mask | output | 4 | Narrow byte-lane enables |
| nar_rsp_valid | input | 1 | Narrow response (read data or write ack) |
| nar_rdata | input | 32 | Narrow read data |

## Verification
The checks assume the narrow target returns exactly one response per accepted request, never before that request's handshake and never while no request is outstanding. They also assume the master holds its request fields steady while `wide_valid` waits for `wide_ready`. The bench target model follows these rules. It latches each narrow request on its handshake and answers once after a random delay of zero to two cycles. The master side presents each access at a cycle boundary and holds it until it is accepted. Ready signals on both sides are randomized to exercise back-pressure.

// File: rtl/be64_split_pkg.sv
package be64_split_pkg;
  localparam int WIDE_BYTES = 8;
  localparam int NAR_BYTES  = 4;
  localparam int BYTE_W     = 8;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} split_state_t;
endpackage

// File: rtl/lane_rev.sv
module lane_rev #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[i*LANE_W +: LANE_W] = din[(LANES-1-i)*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
  import be64_split_pkg::*;
#(
  parameter int WOFS_W = 5,
  localparam int WD_W  = WIDE_BYTES * BYTE_W,
  localparam int ND_W  = NAR_BYTES * BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wide_valid,
  output logic                  wide_ready,
  input  logic                  wide_write,
  input  logic [WOFS_W-1:0]     wide_ofs,
  input  logic [WD_W-1:0]       rev_wdata,
  input  logic [WIDE_BYTES-1:0] rev_mask,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [WD_W-1:0]       acc_data,
  output logic                  nar_valid,
  input  logic                  nar_ready,
  output logic                  nar_write,
  output logic [WOFS_W:0]       nar_ofs,
  output logic [ND_W-1:0]       nar_wdata,
  output logic [NAR_BYTES-1:0]  nar_mask,
  input  logic                  nar_rsp_valid,
  input  logic [ND_W-1:0]       nar_rdata
);
  split_state_t             state;
  logic                     hi_sel;
  logic                     write_q;
  logic [WOFS_W-1:0]        ofs_q;
  logic [WD_W-1:0]          data_q;
  logic [WIDE_BYTES-1:0]    mask_q;
  logic                     lo_any_in, hi_any_in, hi_any_q;

  assign lo_any_in = |rev_mask[NAR_BYTES-1:0];
  assign hi_any_in = |rev_mask[WIDE_BYTES-1:NAR_BYTES];
  assign hi_any_q  = |mask_q[WIDE_BYTES-1:NAR_BYTES];

  assign wide_ready = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_RESP);
  assign nar_valid  = (state == ST_ISSUE);
  assign nar_write  = write_q;
  assign nar_ofs    = {ofs_q, hi_sel};
  assign nar_wdata  = hi_sel ? data_q[WD_W-1:ND_W] : data_q[ND_W-1:0];
  assign nar_mask   = hi_sel ? mask_q[WIDE_BYTES-1:NAR_BYTES] : mask_q[NAR_BYTES-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hi_sel   <= 1'b0;
      write_q  <= 1'b0;
      ofs_q    <= '0;
      data_q   <= '0;
      mask_q   <= '0;
      acc_data <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (wide_valid) begin
          write_q  <= wide_write;
          ofs_q    <= wide_ofs;
          data_q   <= rev_wdata;
          mask_q   <= rev_mask;
          acc_data <= '0;
          hi_sel   <= ~lo_any_in;
          state    <= (lo_any_in || hi_any_in) ? ST_ISSUE : ST_RESP;
        end
        ST_ISSUE: if (nar_ready) state <= ST_WAIT;
        ST_WAIT: if (nar_rsp_valid) begin
          if (hi_sel) acc_data[WD_W-1:ND_W] <= nar_rdata;
          else        acc_data[ND_W-1:0]    <= nar_rdata;
          if (!hi_sel && hi_any_q) begin
            hi_sel <= 1'b1;
            state  <= ST_ISSUE;
          end else begin
            state  <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/be64_splitter.sv
module be64_splitter
  import be64_split_pkg::*;
#(
  parameter int WOFS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_valid,
  output logic              wide_ready,
  input  logic              wide_write,
  input  logic [WOFS_W-1:0] wide_ofs,
  input  logic [63:0]       wide_wdata,
  input  logic [7:0]        wide_mask,
  output logic              wide_rsp_valid,
  input  logic              wide_rsp_ready,
  output logic [63:0]       wide_rdata,
  output logic              nar_valid,
  input  logic              nar_ready,
  output logic              nar_write,
  output logic [WOFS_W:0]   nar_ofs,
  output logic [31:0]       nar_wdata,
  output logic [3:0]        nar_mask,
  input  logic              nar_rsp_valid,
  input  logic [31:0]       nar_rdata
);
  logic [63:0] rev_wdata, acc_data;
  logic [7:0]  rev_mask;

  lane_rev #(.LANES(WIDE_BYTES), .LANE_W(BYTE_W)) u_rev_wdata (.din(wide_wdata), .dout(rev_wdata));
  lane_rev #(.LANES(WIDE_BYTES), .LANE_W(1))      u_rev_mask  (.din(wide_mask),  .dout(rev_mask));
  lane_rev #(.LANES(WIDE_BYTES), .LANE_W(BYTE_W)) u_rev_rdata (.din(acc_data),   .dout(wide_rdata));

  split_ctrl #(.WOFS_W(WOFS_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .wide_valid(wide_valid), .wide_ready(wide_ready), .wide_write(wide_write),
    .wide_ofs(wide_ofs), .rev_wdata(rev_wdata), .rev_mask(rev_mask),
    .rsp_valid(wide_rsp_valid), .rsp_ready(wide_rsp_ready), .acc_data(acc_data),
    .nar_valid(nar_valid), .nar_ready(nar_ready), .nar_write(nar_write),
    .nar_ofs(nar_ofs), .nar_wdata(nar_wdata), .nar_mask(nar_mask),
    .nar_rsp_valid(nar_rsp_valid), .nar_rdata(nar_rdata)
  );
endmodule

// File: rtl/be64_splitter_chk.sv
module be64_splitter_chk #(
  parameter int WOFS_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            wide_ready,
  input logic            wide_rsp_valid,
  input logic            wide_rsp_ready,
  input logic [63:0]     wide_rdata,
  input logic            nar_valid,
  input logic            nar_ready,
  input logic            nar_write,
  input logic [WOFS_W:0] nar_ofs,
  input logic [31:0]     nar_wdata,
  input logic [3:0]      nar_mask
);
  a_r3_lane_active: assert property (@(posedge clk) disable iff (rst)
    nar_valid |-> (nar_mask != 4'h0));

  a_r8_single_txn: assert property (@(posedge clk) disable iff (rst)
    (nar_valid || wide_rsp_valid) |-> !wide_ready);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (nar_valid && !nar_ready) |=> (nar_valid && $stable(nar_ofs) && $stable(nar_wdata)
                                   && $stable(nar_mask) && $stable(nar_write)));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (wide_rsp_valid && !wide_rsp_ready) |=> (wide_rsp_valid && $stable(wide_rdata)));

  a_r11_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wide_ready && !nar_valid && !wide_rsp_valid));

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(nar_valid && wide_rsp_valid));
endmodule

bind be64_splitter be64_splitter_chk #(.WOFS_W(WOFS_W)) u_chk (
  .clk(clk), .rst(rst), .wide_ready(wide_ready), .wide_rsp_valid(wide_rsp_valid),
  .wide_rsp_ready(wide_rsp_ready), .wide_rdata(wide_rdata), .nar_valid(nar_valid),
  .nar_ready(nar_ready), .nar_write(nar_write), .nar_ofs(nar_ofs),
  .nar_wdata(nar_wdata), .nar_mask(nar_mask)
);

// File: tb/test_be64_splitter.sv
module test_be64_splitter;
  localparam int WOFS_W = 5;
  localparam int NWORDS = 2 ** (WOFS_W + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic wide_valid = 0, wide_write = 0, wide_rsp_ready = 0;
  logic [WOFS_W-1:0] wide_ofs = '0;
  logic [63:0] wide_wdata = '0, wide_rdata;
  logic [7:0]  wide_mask = '0;
  logic wide_ready, wide_rsp_valid;
  logic nar_valid, nar_write, nar_ready = 0, nar_rsp_valid = 0;
  logic [WOFS_W:0] nar_ofs;
  logic [31:0] nar_wdata, nar_rdata = '0;
  logic [3:0]  nar_mask;

  int checks = 0, fails = 0;
  logic [31:0] mem [NWORDS];

  always #5 clk = ~clk;

  be64_splitter #(.WOFS_W(WOFS_W)) i_be64_splitter (.*);

  function automatic logic [63:0] rev64(input logic [63:0] d);
    for (int i = 0; i < 8; i++) rev64[8*i +: 8] = d[8*(7-i) +: 8];
  endfunction
  function automatic logic [7:0] rev8(input logic [7:0] m);
    for (int i = 0; i < 8; i++) rev8[i] = m[7-i];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(input logic wr, input logic [WOFS_W-1:0] n,
                     input logic [63:0] d, input logic [7:0] m, input bit rnd);
    logic [63:0] rd = rev64(d), acc = '0, got = '0;
    logic [7:0]  rm = rev8(m);
    logic [WOFS_W:0] a_ofs [2];
    logic [31:0] a_dat [2];
    logic [3:0]  a_msk [2];
    logic        a_wr  [2];
    int na = 0, exp_n = 0, dly = 0, cyc = 0;
    bit busy = 0, done = 0, accepted = 0;
    logic [31:0] pend = '0;
    int exp_h [2];
    // expected access list and read result
    for (int h = 0; h < 2; h++)
      if (rm[4*h +: 4] != 4'h0) begin
        exp_h[exp_n] = h; exp_n++;
        acc[32*h +: 32] = mem[{n, h[0]}];
      end
    @(negedge clk);
    wide_valid = 1; wide_write = wr; wide_ofs = n; wide_wdata = d; wide_mask = m;
    while (!done && cyc < 100) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (accepted) wide_valid = 0;
      if (wide_valid && wide_ready) accepted = 1;
      nar_rsp_valid = 0; nar_ready = 0; wide_rsp_ready = 0;
      if (busy) begin
        if (dly == 0) begin nar_rsp_valid = 1; nar_rdata = pend; busy = 0; end
        else dly--;
      end else if (nar_valid) begin
        nar_ready = rnd ? 1'($urandom % 2) : 1'b1;
        if (nar_ready) begin
          if (na < 2) begin
            a_ofs[na] = nar_ofs; a_dat[na] = nar_wdata; a_msk[na] = nar_mask; a_wr[na] = nar_write;
          end
          na++;
          pend = mem[nar_ofs];
          if (nar_write)
            for (int b = 0; b < 4; b++)
              if (nar_mask[b]) mem[nar_ofs][8*b +: 8] = nar_wdata[8*b +: 8];
          busy = 1; dly = rnd ? $urandom % 3 : 0;
        end
      end
      if (wide_rsp_valid) begin
        wide_rsp_ready = rnd ? 1'($urandom % 2) : 1'b1;
        if (wide_rsp_ready) begin got = wide_rdata; done = 1; end
      end
    end
    @(negedge clk);
    wide_rsp_ready = 0; nar_ready = 0; nar_rsp_valid = 0; wide_valid = 0;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 wide response missing actual=0 expected=1");
    end
    chk("R3/R7 narrow access count", 64'(na), 64'(exp_n));
    for (int k = 0; k < exp_n && k < na; k++) begin
      chk("R2/R5 narrow offset/order", 64'(a_ofs[k]), 64'({n, 1'(exp_h[k])}));
      chk("R4 narrow mask slice", 64'(a_msk[k]), 64'(rm[4*exp_h[k] +: 4]));
      chk("R8 narrow direction", 64'(a_wr[k]), 64'(wr));
      if (wr) chk("R1 narrow write data", 64'(a_dat[k]), 64'(rd[32*exp_h[k] +: 32]));
    end
    if (!wr) chk("R6 wide read data", got, rev64(acc));
    else if (exp_n == 0) chk("R7 empty write result", got, 64'h0);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NWORDS; i++) mem[i] = 32'hA5000000 ^ (i * 32'h01030507);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset wide_ready", 64'(wide_ready), 64'h1);
    chk("R11 reset nar_valid", 64'(nar_valid), 64'h0);
    chk("R11 reset wide_rsp_valid", 64'(wide_rsp_valid), 64'h0);
    // directed corner cases
    txn(1, 5'd3, 64'h0011223344556677, 8'hFF, 0);   // R1 full write
    txn(0, 5'd3, 64'h0, 8'hFF, 0);                  // R6 full read back
    txn(0, 5'd3, 64'h0, 8'h0F, 0);                  // R6 only reversed-high half
    txn(0, 5'd3, 64'h0, 8'hF0, 0);                  // R6 only reversed-low half
    txn(0, 5'd7, 64'h0, 8'h00, 0);                  // R7 empty read
    txn(1, 5'd7, 64'hFFFFFFFFFFFFFFFF, 8'h00, 0);   // R7 empty write
    txn(0, 5'd7, 64'h0, 8'hFF, 0);                  // R7 memory untouched
    txn(1, 5'd31, 64'h8877665544332211, 8'h81, 0);  // R4 single lanes at each end
    txn(0, 5'd31, 64'h0, 8'h18, 0);                 // R5 one lane per half
    txn(1, 5'd0, 64'hDEADBEEFCAFEF00D, 8'h01, 0);   // R2 one byte, high offset
    for (int t = 0; t < 300; t++)
      txn(1'($urandom % 2), 5'($urandom), {$urandom, $urandom}, 8'($urandom), 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule